// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block owns the command port of a DDR3 device from reset until the device is ready for normal traffic. After a start pulse it walks a fixed list of steps. It raises the device reset line, on-die termination and clock enable together, then pulses clock enable low for a short while. Next it loads the four mode registers in the order 2, 3, 1, 0, issues a long ZQ calibration, and finally passes the command port to the regular memory controller. A settling interval follows, after which a completion flag comes up.

The command outputs use the single-phase DFI convention, with active-low chip select and strobes. Each command occupies the port for one cycle only. Every other cycle is a deselect, with all strobes high and address and bank at zero. Every wait is a parameter counted in controller clock cycles, so a system can match its clock rate and a bench can shorten the run.

Top module: `ddr3_init_seq`

## Requirements
- R1: After a synchronous reset, and for as long as start has not been seen, dfi_reset_n, dfi_cke, dfi_odt, ctrl_sel and init_done are all 0, and dfi_cs_n is 1.
- R2: Let cycle 0 be the cycle after the clock edge that samples start high in idle. From cycle 0 on, dfi_reset_n and dfi_odt are 1, and dfi_cke is 1 for cycles 0 to T_POWER-1.
- R3: dfi_cke is 0 for exactly T_CKE_LO cycles, starting at cycle T_POWER, while dfi_reset_n and dfi_odt stay 1. It is then 1 for the rest of the sequence.
- R4: Mode-register loads use {cs_n,ras_n,cas_n,we_n} = 4'b0000. They appear at cycles P, P+T_MRD, P+2*T_MRD and P+3*T_MRD, where P = T_POWER+T_CKE_LO+T_CKE_HI. Their bank/address pairs are, in that order, 2/0x200, 3/0x000, 1/0x006 and 0/0x320.
- R5: A command holds the port for a single cycle. On every other cycle the four strobes are high and address and bank are 0. Each command step lasts at least 2 cycles.
- R6: A ZQ calibration appears T_MR0 cycles after the last mode-register load. It uses strobes 4'b0110, bank 0 and address 0x400, with only A10 set.
- R7: ctrl_sel becomes 1 T_ZQ cycles after the ZQ command and stays 1 until reset.
- R8: init_done becomes 1 T_SETTLE cycles after ctrl_sel rises and stays 1 until reset.
- R9: Start has no effect while the sequence runs or after it has finished. No extra command appears and no timing shifts.
- R10: Asserting reset in the middle of a sequence returns every output to its R1 value on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins the sequence when seen in idle |
| dfi_cke | output | 1 | Clock enable to the device |
| dfi_odt | output | 1 | On-die termination enable |
| dfi_reset_n | output | 1 | Device reset, active low |
| dfi_cs_n | output | 1 | Chip select, active low |
| dfi_ras_n | output | 1 | Row strobe, active low |
| dfi_cas_n | output | 1 | Column strobe, active low |
| dfi_we_n | output | 1 | Write enable, active low |
| dfi_bank | output | BANK_W | Bank address carried with a command |
| dfi_address | output | ADDR_W | Address carried with a command |
| ctrl_sel | output | 1 | 1 hands the command port to the memory controller |
| init_done | output | 1 | Initialization complete |

## Verification
The sequence is run with shortened, unequal waits. This means a step that ends one cycle early or late, or two steps that swap their lengths, shows up as a command at the wrong cycle. Start pulses are injected during the mode-register phase and again after completion. These separate a machine that ignores start from one that restarts or adds commands. A reset in the middle of the sequence, followed by a clean second run, shows that no stale counter or step state survives a reset.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_POWER, ST_CKE_LO, ST_CKE_HI,
    ST_LMR2, ST_LMR3, ST_LMR1, ST_LMR0,
    ST_ZQCAL, ST_HANDOVER, ST_DONE
  } step_e;

  typedef enum logic [1:0] { CMD_NONE, CMD_MRS, CMD_ZQ } cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } strobe_t;

  // mode-register payloads and ZQ long calibration address
  localparam logic [15:0] MR2_VAL = 16'h0200;
  localparam logic [15:0] MR3_VAL = 16'h0000;
  localparam logic [15:0] MR1_VAL = 16'h0006;
  localparam logic [15:0] MR0_VAL = 16'h0320;
  localparam logic [15:0] ZQL_VAL = 16'h0400;

  function automatic strobe_t cmd_strobes(cmd_e c);
    case (c)
      CMD_MRS: return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      CMD_ZQ:  return '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};
      default: return '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
  endfunction

  function automatic int unsigned max_of(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/init_step_rom.sv
module init_step_rom
  import ddr3_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned BANK_W = 3
) (
  input  step_e              step,
  output cmd_e               cmd,
  output logic [BANK_W-1:0]  bank,
  output logic [ADDR_W-1:0]  addr,
  output logic               cke,
  output logic               odt,
  output logic               rst_n,
  output logic               sel,
  output logic               done
);
  always_comb begin
    cmd  = CMD_NONE;
    bank = '0;
    addr = '0;
    case (step)
      ST_LMR2:  begin cmd = CMD_MRS; bank = BANK_W'(2); addr = ADDR_W'(MR2_VAL); end
      ST_LMR3:  begin cmd = CMD_MRS; bank = BANK_W'(3); addr = ADDR_W'(MR3_VAL); end
      ST_LMR1:  begin cmd = CMD_MRS; bank = BANK_W'(1); addr = ADDR_W'(MR1_VAL); end
      ST_LMR0:  begin cmd = CMD_MRS; bank = BANK_W'(0); addr = ADDR_W'(MR0_VAL); end
      ST_ZQCAL: begin cmd = CMD_ZQ;  bank = BANK_W'(0); addr = ADDR_W'(ZQL_VAL); end
      default:  ;
    endcase
  end

  always_comb begin
    rst_n = (step != ST_IDLE);
    odt   = (step != ST_IDLE);
    cke   = (step != ST_IDLE) && (step != ST_CKE_LO);
    sel   = (step == ST_HANDOVER) || (step == ST_DONE);
    done  = (step == ST_DONE);
  end
endmodule

// File: rtl/init_wait_timer.sv
module init_wait_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             hold,
  input  logic [CNT_W-1:0] len,
  output logic             first,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (!hold)     cnt_q <= cnt_q + CNT_W'(1);
  end

  assign first = (cnt_q == '0);
  assign last  = (cnt_q == len - CNT_W'(1));
endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
  import ddr3_init_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned BANK_W   = 3,
  parameter int unsigned T_POWER  = 16,
  parameter int unsigned T_CKE_LO = 16,
  parameter int unsigned T_CKE_HI = 16,
  parameter int unsigned T_MRD    = 4,
  parameter int unsigned T_MR0    = 200,
  parameter int unsigned T_ZQ     = 200,
  parameter int unsigned T_SETTLE = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              dfi_cke,
  output logic              dfi_odt,
  output logic              dfi_reset_n,
  output logic              dfi_cs_n,
  output logic              dfi_ras_n,
  output logic              dfi_cas_n,
  output logic              dfi_we_n,
  output logic [BANK_W-1:0] dfi_bank,
  output logic [ADDR_W-1:0] dfi_address,
  output logic              ctrl_sel,
  output logic              init_done
);
  localparam int unsigned MAX_LEN = max_of(max_of(max_of(T_POWER, T_CKE_LO),
                                                  max_of(T_CKE_HI, T_MRD)),
                                           max_of(max_of(T_MR0, T_ZQ), T_SETTLE));
  localparam int unsigned CNT_W = $clog2(MAX_LEN + 1);

  // length of each timed step in cycles
  function automatic logic [CNT_W-1:0] step_len(step_e s);
    case (s)
      ST_POWER:    return CNT_W'(T_POWER);
      ST_CKE_LO:   return CNT_W'(T_CKE_LO);
      ST_CKE_HI:   return CNT_W'(T_CKE_HI);
      ST_LMR2, ST_LMR3, ST_LMR1:
                   return CNT_W'(T_MRD);
      ST_LMR0:     return CNT_W'(T_MR0);
      ST_ZQCAL:    return CNT_W'(T_ZQ);
      ST_HANDOVER: return CNT_W'(T_SETTLE);
      default:     return CNT_W'(1);
    endcase
  endfunction

  step_e step_q, step_d;
  logic  seq_active, step_change, wait_first, wait_last, cmd_fire;

  cmd_e              rom_cmd;
  logic [BANK_W-1:0] rom_bank;
  logic [ADDR_W-1:0] rom_addr;
  logic              rom_cke, rom_odt, rom_rst_n, rom_sel, rom_done;
  strobe_t           strobes;

  assign seq_active = (step_q != ST_IDLE) && (step_q != ST_DONE);

  always_comb begin
    step_d = step_q;
    if (step_q == ST_IDLE && start)   step_d = ST_POWER;
    else if (seq_active && wait_last) step_d = step_e'(step_q + 4'd1);
  end

  assign step_change = (step_d != step_q);

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_IDLE;
    else     step_q <= step_d;
  end

  init_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (step_change),
    .hold    (!seq_active),
    .len     (step_len(step_q)),
    .first   (wait_first),
    .last    (wait_last)
  );

  init_step_rom #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_rom (
    .step  (step_q),
    .cmd   (rom_cmd),
    .bank  (rom_bank),
    .addr  (rom_addr),
    .cke   (rom_cke),
    .odt   (rom_odt),
    .rst_n (rom_rst_n),
    .sel   (rom_sel),
    .done  (rom_done)
  );

  assign cmd_fire = seq_active && wait_first && (rom_cmd != CMD_NONE);
  assign strobes  = cmd_strobes(cmd_fire ? rom_cmd : CMD_NONE);

  assign dfi_cs_n    = strobes.cs_n;
  assign dfi_ras_n   = strobes.ras_n;
  assign dfi_cas_n   = strobes.cas_n;
  assign dfi_we_n    = strobes.we_n;
  assign dfi_bank    = cmd_fire ? rom_bank : '0;
  assign dfi_address = cmd_fire ? rom_addr : '0;
  assign dfi_cke     = rom_cke;
  assign dfi_odt     = rom_odt;
  assign dfi_reset_n = rom_rst_n;
  assign ctrl_sel    = rom_sel;
  assign init_done   = rom_done;
endmodule

// File: rtl/ddr3_init_seq_chk.sv
module ddr3_init_seq_chk #(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned BANK_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              dfi_cke,
  input logic              dfi_odt,
  input logic              dfi_reset_n,
  input logic              dfi_cs_n,
  input logic              dfi_ras_n,
  input logic              dfi_cas_n,
  input logic              dfi_we_n,
  input logic [BANK_W-1:0] dfi_bank,
  input logic [ADDR_W-1:0] dfi_address,
  input logic              ctrl_sel,
  input logic              init_done,
  input logic              cmd_fire
);
  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> (!dfi_cke && !dfi_reset_n && !dfi_odt && !init_done && !ctrl_sel && dfi_cs_n));

  assert_cke_drop_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(dfi_cke) && !$past(rst)) |-> (dfi_reset_n && dfi_odt));

  assert_mrs_form_R4: assert property (@(posedge clk) disable iff (rst)
    (!dfi_cs_n && !dfi_ras_n) |-> (!dfi_cas_n && !dfi_we_n && dfi_cke && dfi_reset_n));

  assert_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    cmd_fire |=> dfi_cs_n);

  assert_zq_form_R6: assert property (@(posedge clk) disable iff (rst)
    (!dfi_cs_n && dfi_ras_n) |->
      (dfi_cas_n && !dfi_we_n && dfi_bank == '0 && dfi_address == ADDR_W'(16'h0400)));

  assert_sel_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl_sel |=> ctrl_sel);

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  assert_done_after_sel_R8: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (ctrl_sel && dfi_cs_n));
endmodule

bind ddr3_init_seq ddr3_init_seq_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .dfi_cke     (dfi_cke),
  .dfi_odt     (dfi_odt),
  .dfi_reset_n (dfi_reset_n),
  .dfi_cs_n    (dfi_cs_n),
  .dfi_ras_n   (dfi_ras_n),
  .dfi_cas_n   (dfi_cas_n),
  .dfi_we_n    (dfi_we_n),
  .dfi_bank    (dfi_bank),
  .dfi_address (dfi_address),
  .ctrl_sel    (ctrl_sel),
  .init_done   (init_done),
  .cmd_fire    (cmd_fire)
);

// File: tb/ddr3_init_seq_test.sv
module ddr3_init_seq_test;
  localparam int TP = 3, TLO = 2, THI = 4, TMRD = 3, TMR0 = 6, TZQ = 5, TSET = 7;
  localparam int S_MR2  = TP + TLO + THI;
  localparam int S_ZQ   = S_MR2 + 3 * TMRD + TMR0;
  localparam int S_SEL  = S_ZQ + TZQ;
  localparam int S_DONE = S_SEL + TSET;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic cke, odt, reset_n, cs_n, ras_n, cas_n, we_n, sel, done;
  logic [2:0]  bank;
  logic [13:0] addr;

  always #4 clk = ~clk;

  ddr3_init_seq #(
    .ADDR_W(14), .BANK_W(3), .T_POWER(TP), .T_CKE_LO(TLO), .T_CKE_HI(THI),
    .T_MRD(TMRD), .T_MR0(TMR0), .T_ZQ(TZQ), .T_SETTLE(TSET)
  ) uut (
    .clk(clk), .rst(rst), .start(start),
    .dfi_cke(cke), .dfi_odt(odt), .dfi_reset_n(reset_n),
    .dfi_cs_n(cs_n), .dfi_ras_n(ras_n), .dfi_cas_n(cas_n), .dfi_we_n(we_n),
    .dfi_bank(bank), .dfi_address(addr), .ctrl_sel(sel), .init_done(done)
  );

  typedef struct {
    int          t;
    logic [3:0]  s;
    logic [2:0]  b;
    logic [13:0] a;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver side: expected commands from the requirements
  task automatic push_cmd(int t, logic [3:0] s, logic [2:0] b, logic [13:0] a);
    exp_t e;
    e.t = t; e.s = s; e.b = b; e.a = a;
    exp_q.push_back(e);
  endtask

  // monitor: owns the cycle counter of a run
  bit mon_on = 1'b0, mon_prev = 1'b0;
  int mon_t = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      exp_t e;
      if (!mon_prev) mon_t = 0;
      chk("R2", "reset_n", reset_n, 1);
      chk("R2", "odt", odt, 1);
      chk((mon_t < TP) ? "R2" : "R3", "cke", cke,
          (mon_t >= TP && mon_t < TP + TLO) ? 0 : 1);
      chk("R7", "sel", sel, (mon_t >= S_SEL) ? 1 : 0);
      chk((mon_t > S_DONE + 2) ? "R9" : "R8", "done", done, (mon_t >= S_DONE) ? 1 : 0);
      if (!cs_n) begin
        if (exp_q.size() == 0) begin
          chk("R9", "unexpected command cycle", mon_t, 32'hFFFF_FFFF);
        end else begin
          e = exp_q.pop_front();
          chk((e.s == 4'b0110) ? "R6" : "R4", "command cycle", mon_t, e.t);
          chk((e.s == 4'b0110) ? "R6" : "R4", "strobes", {cs_n, ras_n, cas_n, we_n}, e.s);
          chk((e.s == 4'b0110) ? "R6" : "R4", "bank", bank, e.b);
          chk((e.s == 4'b0110) ? "R6" : "R4", "address", addr, e.a);
        end
      end else begin
        chk("R5", "idle strobes", {ras_n, cas_n, we_n}, 3'b111);
        chk("R5", "idle bank/address", {bank, addr}, 0);
      end
      mon_t++;
    end
    mon_prev = mon_on;
  end

  task automatic check_idle(string req);
    @(negedge clk);
    chk(req, "idle cke", cke, 0);
    chk(req, "idle reset_n", reset_n, 0);
    chk(req, "idle odt", odt, 0);
    chk(req, "idle sel/done", {sel, done}, 0);
    chk(req, "idle cs_n", cs_n, 1);
  endtask

  task automatic run_full();
    exp_q.delete();
    push_cmd(S_MR2,            4'b0000, 3'd2, 14'h200);
    push_cmd(S_MR2 + TMRD,     4'b0000, 3'd3, 14'h000);
    push_cmd(S_MR2 + 2 * TMRD, 4'b0000, 3'd1, 14'h006);
    push_cmd(S_MR2 + 3 * TMRD, 4'b0000, 3'd0, 14'h320);
    push_cmd(S_ZQ,             4'b0110, 3'd0, 14'h400);
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0; mon_on = 1'b1;
    for (int i = 1; i <= S_DONE + 8; i++) begin
      @(posedge clk); #1;
      // R9: start pulses mid-sequence and after completion
      start = (i == 10 || i == S_DONE + 2) ? 1'b1 : 1'b0;
    end
    start = 1'b0;
    @(negedge clk); #1 mon_on = 1'b0;
    chk("R4", "commands left unseen", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    for (int i = 0; i < 4; i++) check_idle("R1");
    run_full();
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    check_idle("R10");
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (S_MR2 + 1) @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    check_idle("R10");
    for (int i = 0; i < 3; i++) check_idle("R1");
    run_full();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule